// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial link (bit clock, word select, data) and turns the time-multiplexed channel words into parallel 20-bit samples. It works only as a slave. The bit clock and word select both come from outside. The block oversamples them with its own core clock and acts on each rising edge of the bit clock.

A 3-bit mode input picks the framing. Mode 000 selects MSB-first framing in the I2S style, with words of up to 20 bits and a 256fs system clock. Modes 001, 010 and 011 select LSB-aligned framing with a fixed length of 16, 18 or 20 bits, using a 384fs system clock. In the LSB-aligned modes the data line idles on the MSB, so the configured length alone decides where a word starts. Codes 1xx are not valid.

Once the right word of a stereo frame is complete, the block puts the left and right samples out together with a single-cycle strobe. Samples shorter than 20 bits are left-justified and zero-filled.

Top module: `audio_serial_rx`

## Requirements
- R1: `fmt_ok` is 1 for mode codes 000 to 011 and 0 for 100 to 111. `ratio_384` is 1 for codes 001, 010 and 011 and 0 for every other code. Both outputs follow `mode` combinationally.
- R2: In mode 000, word select low marks the left channel. The bit sampled on the first bit-clock rise after a word-select change is the MSB (output bit 19). The following rises fill bits 18 down to 0.
- R3: In mode 000, data bits past the 20th in a slot have no effect on the output sample.
- R4: In mode 000, when a slot carries fewer than 20 bits before the next word-select change, the output bits that were not received read as zero.
- R5: In modes 001, 010 and 011, the N bits sampled on the N rises just before a word-select change form the word, where N is 16, 18 or 20 for those codes. Bits sampled earlier in the slot have no effect.
- R6: An LSB-aligned word of N < 20 bits appears in output bits 19 down to 20-N, and the low 20-N output bits are zero.
- R7: `pcm_valid` pulses for exactly one cycle per stereo frame, and only after a left word followed by a right word. The left and right samples are presented together and hold their value until the next pulse.
- R8: `pcm_valid` is high in the third core-clock cycle after the input change where the bit clock rises with word select going from right to left. It is low in the cycle before that.
- R9: With an invalid mode code, `pcm_valid` never asserts.
- R10: After reset, `pcm_valid` is 0 and both samples are zero. The first bit-clock rise after reset only records the word-select level and never counts as a channel change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External serial bit clock |
| ws | input | 1 | External word select (0 = left) |
| sd | input | 1 | Serial data |
| mode | input | 3 | Framing and system-clock ratio code |
| fmt_ok | output | 1 | Mode code is valid |
| ratio_384 | output | 1 | 1 = 384fs system clock, 0 = 256fs |
| pcm_valid | output | 1 | One-cycle strobe: a stereo pair is ready |
| pcm_left | output | 20 | Left sample, left-justified |
| pcm_right | output | 20 | Right sample, left-justified |

## Verification
Three registers sit between the serial pins and the strobe: input capture, word assembly and pair output. So the pair is due in the third core cycle after the bench raises the bit clock on the frame-closing bit. The bench drives inputs on the falling core-clock edge and holds each bit-clock phase for a fixed number of cycles. On the closing bit it samples the strobe on the second and third falling edges after the rise, and expects it low and then high with the expected samples. Frame counts taken across whole sweeps confirm one strobe per frame, and confirm that no strobe appears under an invalid mode.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int WORD_W = 20;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    typedef enum logic { FMT_I2S = 1'b0, FMT_LSB = 1'b1 } fmt_e;

    typedef struct packed {
        logic             ok;
        fmt_e             fmt;
        logic [LEN_W-1:0] len;
        logic             fs384;
    } rx_cfg_t;

    typedef struct packed {
        logic              ch;    // 0 = left, 1 = right
        logic [WORD_W-1:0] data;
    } word_t;

    function automatic rx_cfg_t decode_mode(input logic [2:0] m);
        rx_cfg_t c;
        c.ok    = ~m[2];
        c.fmt   = (m[1:0] == 2'b00) ? FMT_I2S : FMT_LSB;
        c.fs384 = ~m[2] & (m[1:0] != 2'b00);
        unique case (m[1:0])
            2'b01:   c.len = LEN_W'(WORD_W - 4);
            2'b10:   c.len = LEN_W'(WORD_W - 2);
            default: c.len = LEN_W'(WORD_W);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/srx_line_front.sv
module srx_line_front (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic ws,
    input  logic sd,
    output logic rise,
    output logic ws_edge,
    output logic ws_old,
    output logic sd_s
);
    logic bclk_r, ws_r, sd_r, bclk_q, ws_last, primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_r  <= 1'b0;
            ws_r    <= 1'b0;
            sd_r    <= 1'b0;
            bclk_q  <= 1'b0;
            ws_last <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_r <= bclk;
            ws_r   <= ws;
            sd_r   <= sd;
            bclk_q <= bclk_r;
            if (rise) begin
                ws_last <= ws_r;
                primed  <= 1'b1;
            end
        end
    end

    assign rise    = bclk_r & ~bclk_q;
    assign ws_edge = rise & primed & (ws_r != ws_last);
    assign ws_old  = ws_last;
    assign sd_s    = sd_r;

    // R10: the first rise after reset only primes the word-select history
    assert_first_rise_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (rise && !primed) |-> !ws_edge);

endmodule

// File: rtl/srx_word_capture.sv
module srx_word_capture
    import audio_rx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic    clk,
    input  logic    rst,
    input  rx_cfg_t cfg,
    input  logic    rise,
    input  logic    ws_edge,
    input  logic    ws_old,
    input  logic    sd,
    output logic    word_vld,
    output word_t   word
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  acc, acc_in, sh, lsb_word;

    always_comb begin
        acc_in = acc;
        if (int'(cnt) < W) acc_in[W-1-int'(cnt)] = sd;
    end

    assign lsb_word = sh << (W - int'(cfg.len));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            acc      <= '0;
            sh       <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (rise) begin
                sh <= {sh[W-2:0], sd};
                if (ws_edge) begin
                    word_vld  <= cfg.ok;
                    word.ch   <= ws_old;
                    word.data <= (cfg.fmt == FMT_I2S) ? acc_in : lsb_word;
                    acc       <= '0;
                    cnt       <= '0;
                end else begin
                    acc <= acc_in;
                    if (int'(cnt) < W) cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3: the bit position counter never runs past the word width
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= W);

    // R7: completed words are separate single-cycle events
    assert_word_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

endmodule

// File: rtl/srx_pair_out.sv
module srx_pair_out
    import audio_rx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_vld,
    input  word_t        word,
    output logic         valid,
    output logic [W-1:0] left,
    output logic [W-1:0] right
);
    logic [W-1:0] left_hold;
    logic         have_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            have_left <= 1'b0;
            valid     <= 1'b0;
            left      <= '0;
            right     <= '0;
        end else begin
            valid <= 1'b0;
            if (word_vld) begin
                if (!word.ch) begin
                    left_hold <= word.data;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left      <= left_hold;
                    right     <= word.data;
                    valid     <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

    // R7: strobe is one cycle wide
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7: a pair is only emitted after a left word was held
    assert_left_before_right_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(have_left));

    // R7: outputs hold between strobes
    assert_pair_held_R7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(left) && $stable(right)));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import audio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              ws,
    input  logic              sd,
    input  logic [2:0]        mode,
    output logic              fmt_ok,
    output logic              ratio_384,
    output logic              pcm_valid,
    output logic [WORD_W-1:0] pcm_left,
    output logic [WORD_W-1:0] pcm_right
);
    rx_cfg_t cfg;
    logic    rise, ws_edge, ws_old, sd_s, word_vld;
    word_t   word;

    assign cfg       = decode_mode(mode);
    assign fmt_ok    = cfg.ok;
    assign ratio_384 = cfg.fs384;

    srx_line_front front_i (
        .clk(clk), .rst(rst), .bclk(bclk), .ws(ws), .sd(sd),
        .rise(rise), .ws_edge(ws_edge), .ws_old(ws_old), .sd_s(sd_s)
    );

    srx_word_capture #(.W(WORD_W)) capture_i (
        .clk(clk), .rst(rst), .cfg(cfg), .rise(rise), .ws_edge(ws_edge),
        .ws_old(ws_old), .sd(sd_s), .word_vld(word_vld), .word(word)
    );

    srx_pair_out #(.W(WORD_W)) pair_i (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
        .valid(pcm_valid), .left(pcm_left), .right(pcm_right)
    );

    // R9: an invalid code two cycles back leaves the strobe low
    assert_invalid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg.ok |=> ##1 !pcm_valid);

    // R5: LSB-aligned lengths are limited to the three legal values
    assert_lsb_len_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.ok && cfg.fmt == FMT_LSB) |->
        (int'(cfg.len) == WORD_W || int'(cfg.len) == WORD_W - 2 || int'(cfg.len) == WORD_W - 4));

    // R6: 16-bit LSB-aligned words leave the low four bits zero
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && $past(mode == 3'b001, 2)) |->
        (pcm_left[3:0] == 4'h0 && pcm_right[3:0] == 4'h0));

endmodule

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, ws = 1'b1, sd = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        fmt_ok, ratio_384, pcm_valid;
    logic [19:0] pcm_left, pcm_right;

    int n_checks = 0;
    int n_errors = 0;
    int n_valid  = 0;
    int exp_valid = 0;
    logic [19:0] exp_l = '0, exp_r = '0;
    string       exp_tag = "R2";

    always #2.5 clk = ~clk;

    audio_serial_rx dut_i (
        .clk(clk), .rst(rst), .bclk(bclk), .ws(ws), .sd(sd), .mode(mode),
        .fmt_ok(fmt_ok), .ratio_384(ratio_384), .pcm_valid(pcm_valid),
        .pcm_left(pcm_left), .pcm_right(pcm_right)
    );

    always @(negedge clk) if (!rst && pcm_valid) n_valid++;

    task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        rst = 1'b1; mode = m; bclk = 1'b0; ws = 1'b1; sd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        n_valid = 0; exp_valid = 0;
    endtask

    // One serial bit; on a closing bit the strobe is checked on the 2nd and 3rd edges
    task automatic send_bit(input logic w, input logic d, input bit chk);
        bclk = 1'b0; ws = w; sd = d;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        if (chk) check(pcm_valid === 1'b0, "R8 strobe early", {19'b0, pcm_valid}, 20'h0);
        @(negedge clk);
        if (chk) begin
            check(pcm_valid === 1'b1, "R8 strobe due", {19'b0, pcm_valid}, 20'h1);
            check(pcm_left === exp_l, {exp_tag, " left"}, pcm_left, exp_l);
            check(pcm_right === exp_r, {exp_tag, " right"}, pcm_right, exp_r);
        end
    endtask

    function automatic logic [19:0] top_bits(input logic [19:0] v, input int s);
        return (s >= 20) ? v : (v & ~(20'hFFFFF >> s));
    endfunction

    task automatic i2s_preamble();
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0);
    endtask

    // Slot bits past the 20th are driven as ones (must be ignored)
    task automatic i2s_frame(input int s, input logic [19:0] l, input logic [19:0] r, input string tag);
        exp_l = top_bits(l, s); exp_r = top_bits(r, s); exp_tag = tag;
        for (int j = 0; j < s; j++)
            send_bit(j == s - 1, (j < 20) ? l[19-j] : 1'b1, 1'b0);
        for (int j = 0; j < s; j++)
            send_bit(j != s - 1, (j < 20) ? r[19-j] : 1'b1, j == s - 1);
        exp_valid++;
    endtask

    // Filler bits ahead of the word are ones (must be ignored)
    task automatic lsb_frame(input int s, input int n, input logic [19:0] l, input logic [19:0] r,
                             input string tag, input bit chk_prev);
        for (int j = 0; j < s; j++) begin
            if (j == 1) begin
                exp_l = l << (20 - n); exp_r = r << (20 - n); exp_tag = tag;
            end
            send_bit(1'b0, (j < s - n) ? 1'b1 : l[n-1-(j-(s-n))], (j == 0) && chk_prev);
        end
        for (int j = 0; j < s; j++)
            send_bit(1'b1, (j < s - n) ? 1'b1 : r[n-1-(j-(s-n))], 1'b0);
        exp_valid++;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [19:0] l, r;
        @(negedge clk);
        do_reset(3'b000);
        @(negedge clk);
        // R10: reset state
        check(pcm_valid === 1'b0, "R10 valid", {19'b0, pcm_valid}, 20'h0);
        check(pcm_left === 20'h0, "R10 left", pcm_left, 20'h0);
        check(pcm_right === 20'h0, "R10 right", pcm_right, 20'h0);

        // R1 and R9: decode of every code
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            #1;
            check(fmt_ok === (m < 4), "R1 fmt_ok", {19'b0, fmt_ok}, {19'b0, 1'(m < 4)});
            check(ratio_384 === (m >= 1 && m <= 3), "R1 ratio", {19'b0, ratio_384},
                  {19'b0, 1'(m >= 1 && m <= 3)});
        end

        // R2, R3: I2S with 32- and 20-bit slots; R4: 16-bit slots
        begin
            int slots[3] = '{32, 20, 16};
            string tags[3] = '{"R3", "R2", "R4"};
            for (int c = 0; c < 3; c++) begin
                do_reset(3'b000);
                i2s_preamble();
                for (int k = 0; k < 4; k++) begin
                    l = 20'((k * 179321 + 12345) & 32'hFFFFF);
                    r = 20'((k * 654323 + 98765) & 32'hFFFFF);
                    if (k == 0) begin l = 20'hFFFFF; r = 20'h80001; end
                    i2s_frame(slots[c], l, r, tags[c]);
                end
                repeat (10) @(negedge clk);
                check(n_valid == exp_valid, "R7 strobe count", 20'(n_valid), 20'(exp_valid));
            end
        end

        // R5, R6: LSB-aligned lengths 16, 18, 20 in 24-bit slots, and 20 in 20-bit slots
        begin
            int lens[4] = '{16, 18, 20, 20};
            int slot[4] = '{24, 24, 24, 20};
            logic [2:0] codes[4] = '{3'b001, 3'b010, 3'b011, 3'b011};
            for (int c = 0; c < 4; c++) begin
                do_reset(codes[c]);
                for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b1, 1'b0);
                for (int k = 0; k < 4; k++) begin
                    logic [19:0] lm;
                    lm = 20'hFFFFF >> (20 - lens[c]);
                    l = 20'((k * 271829 + 4242) & 32'hFFFFF) & lm;
                    r = 20'((k * 314159 + 777) & 32'hFFFFF) & lm;
                    if (k == 1) begin l = lm; r = 20'h00001; end
                    lsb_frame(slot[c], lens[c], l, r, (lens[c] < 20) ? "R6" : "R5", k != 0);
                end
                send_bit(1'b0, 1'b1, 1'b1);
                repeat (10) @(negedge clk);
                check(n_valid == exp_valid, "R7 strobe count", 20'(n_valid), 20'(exp_valid));
                // R7: pair holds after the strobe
                check(pcm_left === exp_l, "R7 left held", pcm_left, exp_l);
            end
        end

        // R9: invalid code yields no strobe
        do_reset(3'b101);
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) lsb_frame(24, 20, 20'h12345, 20'h54321, "R9", 1'b0);
        send_bit(1'b0, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        check(n_valid == 0, "R9 no strobe", 20'(n_valid), 20'h0);
        check(pcm_left === 20'h0, "R9 left untouched", pcm_left, 20'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule